// File: doc/BRIEF.md
# Timer interrupt flag register

This block holds the sticky interrupt-event flags of a 16-bit timer/counter. It watches the counter value against two compare registers and the capture register. It also takes a capture edge event and an overflow event from the counter logic. It sets one flag per event source and raises a per-flag interrupt request when the matching mask bit is set. The counter, the prescaler, the waveform pins and the interrupt vector controller sit outside the block. A single-cycle `tick` input marks every timer clock, so all flag timing is counted in timer ticks rather than system clocks.

Software reads the flags through `rd_data`. It clears a flag by writing a one to that flag's bit; writing a zero leaves the flag unchanged. The interrupt controller clears a flag by pulsing that flag's acknowledge line when it runs the vector. The two compare flags rise one timer tick after the counter equals the compare value. Forced-compare strobes never touch any flag. When the capture register serves as the counter's TOP value, the capture flag records that the counter reached TOP, and capture edges are ignored.

Top module: `tmr_evt_flags`

## Requirements
- R1: After reset, `rd_data` reads 0 and `irq` is 0.
- R2: Compare flag A (read bit 4) or B (read bit 3) sets on the tick after the tick at which `cnt` equals `cmp_a` or `cmp_b`, and it is still clear right after the matching tick.
- R3: A pulse on `force_a` or `force_b` never sets any flag.
- R4: With `top_sel_cap` = 0, a tick with `cap_evt` high sets the capture flag (read bit 5).
- R5: With `top_sel_cap` = 1, the capture flag sets on a tick where `cnt` equals `cap_reg`, and `cap_evt` has no effect.
- R6: A tick with `ovf_evt` high sets the overflow flag (read bit 2).
- R7: A write with a one in a flag's bit position clears that flag; a zero in that position leaves the flag as it was.
- R8: A pulse on `ack` clears the matching flag (ack bit 3 capture, 2 compare A, 1 compare B, 0 overflow).
- R9: When a set event and a clear (write-one or ack) hit the same flag in the same cycle, the flag ends up set.
- R10: Read bits 7, 6, 1 and 0 always read 0, even after a write of 0xFF.
- R11: `irq[i]` equals flag i AND `irq_mask[i]`, using the same index order as `ack`.
- R12: No flag sets in a cycle where `tick` is low, so a compare delay measured with a prescaler spans timer ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer-clock enable, one cycle per timer tick |
| cnt | input | 16 | Current counter value |
| cmp_a | input | 16 | Compare register A |
| cmp_b | input | 16 | Compare register B |
| cap_reg | input | 16 | Capture register value |
| top_sel_cap | input | 1 | High when the capture register is the TOP value |
| cap_evt | input | 1 | Capture edge event |
| ovf_evt | input | 1 | Counter overflow event |
| force_a | input | 1 | Forced-compare strobe, channel A |
| force_b | input | 1 | Forced-compare strobe, channel B |
| ack | input | 4 | Vector acknowledge pulses per flag |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Flag register read value |
| irq_mask | input | 4 | Interrupt enable per flag |
| irq | output | 4 | Interrupt request per flag |

## Verification
The assertions check on every cycle that reserved read bits stay zero and that no flag rises without a tick. They also check that compare flag A rises only one tick after an armed match, never from a strobe, and that ack or write-one clears the overflow flag unless a set coincides. Only the directed scenarios can show that the one-tick delay stretches over idle cycles with a prescaled tick, and that TOP mode swaps the capture source and ignores edges. The same holds for the irq mask pattern and for the zero-leaves-unchanged write rule.

// File: rtl/tfr_pkg.sv
package tfr_pkg;
   localparam int NUM_FLAGS = 4;
   // flag vector index; read bit = FLAG_LSB + index
   localparam int FLG_OVF   = 0;
   localparam int FLG_CMPB  = 1;
   localparam int FLG_CMPA  = 2;
   localparam int FLG_CAP   = 3;
   localparam int FLAG_LSB  = 2;
   localparam int NUM_CMP   = 2;
endpackage

// File: rtl/tfr_cmp_detect.sv
module tfr_cmp_detect #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   output logic             set_o
);
   logic match_q;

   // remember the match seen at this tick, report it at the next tick
   always_ff @(posedge clk) begin
      if (!rst_n)    match_q <= 1'b0;
      else if (tick) match_q <= (cnt == cmp);
   end

   assign set_o = tick & match_q;
endmodule

// File: rtl/tfr_cap_src.sv
module tfr_cap_src #(
   parameter int CNT_W = 16
) (
   input  logic             tick,
   input  logic             top_sel_cap,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cap_reg,
   input  logic             cap_evt,
   output logic             set_o
);
   always_comb begin
      if (top_sel_cap) set_o = tick & (cnt == cap_reg);
      else             set_o = tick & cap_evt;
   end
endmodule

// File: rtl/tfr_flag_bit.sv
module tfr_flag_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   // set has priority over clear so no event is lost
   always_ff @(posedge clk) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags #(
   parameter int CNT_W = 16,
   parameter int REG_W = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           tick,
   input  logic [CNT_W-1:0]               cnt,
   input  logic [CNT_W-1:0]               cmp_a,
   input  logic [CNT_W-1:0]               cmp_b,
   input  logic [CNT_W-1:0]               cap_reg,
   input  logic                           top_sel_cap,
   input  logic                           cap_evt,
   input  logic                           ovf_evt,
   input  logic                           force_a,
   input  logic                           force_b,
   input  logic [tfr_pkg::NUM_FLAGS-1:0]  ack,
   input  logic                           wr_en,
   input  logic [REG_W-1:0]               wr_data,
   output logic [REG_W-1:0]               rd_data,
   input  logic [tfr_pkg::NUM_FLAGS-1:0]  irq_mask,
   output logic [tfr_pkg::NUM_FLAGS-1:0]  irq
);
   import tfr_pkg::*;

   localparam int FLAG_MSB = FLAG_LSB + NUM_FLAGS - 1;

   initial begin
      if (REG_W < FLAG_MSB + 2) $error("REG_W too narrow for flag layout");
      if (CNT_W < 2)            $error("CNT_W must be at least 2");
   end

   logic [NUM_FLAGS-1:0] set_v;
   logic [NUM_FLAGS-1:0] clr_v;
   logic [NUM_FLAGS-1:0] flags;
   logic [CNT_W-1:0]     cmp_arr [NUM_CMP];

   assign cmp_arr[0] = cmp_a;
   assign cmp_arr[1] = cmp_b;

   // forced-compare strobes must not reach the flags
   logic unused_strobes;
   assign unused_strobes = &{1'b0, force_a, force_b,
                             wr_data[REG_W-1:FLAG_MSB+1], wr_data[FLAG_LSB-1:0]};

   for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
      tfr_cmp_detect #(.CNT_W(CNT_W)) u_det (
         .clk   (clk),
         .rst_n (rst_n),
         .tick  (tick),
         .cnt   (cnt),
         .cmp   (cmp_arr[c]),
         .set_o (set_v[FLG_CMPA - c])
      );
   end

   tfr_cap_src #(.CNT_W(CNT_W)) u_cap (
      .tick        (tick),
      .top_sel_cap (top_sel_cap),
      .cnt         (cnt),
      .cap_reg     (cap_reg),
      .cap_evt     (cap_evt),
      .set_o       (set_v[FLG_CAP])
   );

   assign set_v[FLG_OVF] = tick & ovf_evt;

   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      assign clr_v[f] = ack[f] | (wr_en & wr_data[FLAG_LSB + f]);
      tfr_flag_bit u_bit (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set_v[f]),
         .clr_i  (clr_v[f]),
         .flag_o (flags[f])
      );
   end

   always_comb begin
      rd_data = '0;
      rd_data[FLAG_MSB:FLAG_LSB] = flags;
   end

   assign irq = flags & irq_mask;
endmodule

// File: rtl/tmr_evt_flags_chk.sv
module tmr_evt_flags_chk #(
   parameter int CNT_W = 16,
   parameter int REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp_a,
   input logic             ovf_evt,
   input logic [3:0]       ack,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic [REG_W-1:0] rd_data
);
   logic armed_a;

   always_ff @(posedge clk) begin
      if (!rst_n)    armed_a <= 1'b0;
      else if (tick) armed_a <= (cnt == cmp_a);
   end

   p_cmpa_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick && armed_a |=> rd_data[4]);

   // R3: compare A flag rises only from an armed match, never from a strobe
   p_cmpa_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[4]) |-> $past(tick && armed_a));

   p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tick && ovf_evt |=> rd_data[2]);

   p_wr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_data[2] && !(tick && ovf_evt) |=> !rd_data[2]);

   p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack[0] && !(tick && ovf_evt) |=> !rd_data[2]);

   p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[7:6] == 2'b00 && rd_data[1:0] == 2'b00);

   p_rise_needs_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (|(rd_data & ~$past(rd_data))) |-> $past(tick));
endmodule

bind tmr_evt_flags tmr_evt_flags_chk #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .cnt     (cnt),
   .cmp_a   (cmp_a),
   .ovf_evt (ovf_evt),
   .ack     (ack),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_data (rd_data)
);

// File: tb/test_tmr_evt_flags.sv
`timescale 1ns/100ps
module test_tmr_evt_flags;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [15:0] cnt = 16'h3333;
   logic [15:0] cmp_a = 16'd100;
   logic [15:0] cmp_b = 16'd200;
   logic [15:0] cap_reg = 16'd500;
   logic        top_sel_cap = 1'b0;
   logic        cap_evt = 1'b0;
   logic        ovf_evt = 1'b0;
   logic        force_a = 1'b0;
   logic        force_b = 1'b0;
   logic [3:0]  ack = 4'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = 8'h00;
   logic [7:0]  rd_data;
   logic [3:0]  irq_mask = 4'b0;
   logic [3:0]  irq;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tmr_evt_flags i_tmr_evt_flags (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cmp_a(cmp_a),
      .cmp_b(cmp_b), .cap_reg(cap_reg), .top_sel_cap(top_sel_cap),
      .cap_evt(cap_evt), .ovf_evt(ovf_evt), .force_a(force_a),
      .force_b(force_b), .ack(ack), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .irq_mask(irq_mask), .irq(irq)
   );

   task automatic cyc(int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(string req, int act, int exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic clear_all();
      wr_en = 1'b1; wr_data = 8'hFF; cyc();
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic t_reset();
      chk("R1 rd_data", rd_data, 0);
      chk("R1 irq", irq, 0);
   endtask

   task automatic t_compare();
      tick = 1'b1;
      cnt = 16'd100; cyc();
      chk("R2 A not in match tick", rd_data[4], 0);
      cnt = 16'd101; cyc();
      chk("R2 A after one tick", rd_data[4], 1);
      cnt = 16'd200; cyc();
      chk("R2 B not in match tick", rd_data[3], 0);
      cnt = 16'h3333; cyc();
      chk("R2 B after one tick", rd_data[3], 1);
      wr_en = 1'b1; wr_data = 8'h10; cyc();
      wr_en = 1'b0; wr_data = 8'h00;
      chk("R7 write one clears A", rd_data[4], 0);
      chk("R7 zero leaves B", rd_data[3], 1);
      clear_all();
      chk("R7 all clear", rd_data, 0);
      tick = 1'b0;
   endtask

   task automatic t_prescaled();
      cnt = 16'd100; tick = 1'b1; cyc();
      tick = 1'b0; cnt = 16'd101; cyc(3);
      chk("R12 no set without tick", rd_data[4], 0);
      tick = 1'b1; cyc();
      tick = 1'b0;
      chk("R2 set on next timer tick", rd_data[4], 1);
      cnt = 16'h3333; tick = 1'b1; cyc(); tick = 1'b0;
      clear_all();
   endtask

   task automatic t_force();
      tick = 1'b1; force_a = 1'b1; force_b = 1'b1; cyc(3);
      force_a = 1'b0; force_b = 1'b0; cyc();
      tick = 1'b0;
      chk("R3 strobes set nothing", rd_data, 0);
   endtask

   task automatic t_capture();
      top_sel_cap = 1'b0;
      cap_evt = 1'b1; cyc();
      chk("R12 capture needs tick", rd_data[5], 0);
      tick = 1'b1; cyc();
      cap_evt = 1'b0; tick = 1'b0;
      chk("R4 capture edge sets", rd_data[5], 1);
      ack = 4'b1000; cyc(); ack = 4'b0;
      chk("R8 ack clears capture", rd_data[5], 0);
   endtask

   task automatic t_top();
      top_sel_cap = 1'b1; tick = 1'b1;
      cnt = 16'd10; cap_evt = 1'b1; cyc();
      chk("R5 edge ignored in TOP mode", rd_data[5], 0);
      cap_evt = 1'b0; cnt = 16'd500; cyc();
      chk("R5 TOP reached sets capture", rd_data[5], 1);
      cnt = 16'h3333; tick = 1'b0; top_sel_cap = 1'b0;
      clear_all();
   endtask

   task automatic t_ovf();
      tick = 1'b1; ovf_evt = 1'b1; cyc();
      ovf_evt = 1'b0; tick = 1'b0;
      chk("R6 overflow sets", rd_data[2], 1);
      tick = 1'b1; ovf_evt = 1'b1; wr_en = 1'b1; wr_data = 8'h04; ack = 4'b0001; cyc();
      tick = 1'b0; ovf_evt = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
      chk("R9 set wins over clear", rd_data[2], 1);
      ack = 4'b0001; cyc(); ack = 4'b0;
      chk("R8 ack clears overflow", rd_data[2], 0);
   endtask

   task automatic t_layout();
      tick = 1'b1; ovf_evt = 1'b1; cap_evt = 1'b1; cyc();
      tick = 1'b0; ovf_evt = 1'b0; cap_evt = 1'b0;
      chk("R10 layout capture+overflow", rd_data, 8'h24);
      irq_mask = 4'b1000; cyc();
      chk("R11 irq masked", irq, 4'b1000);
      irq_mask = 4'b1111; cyc();
      chk("R11 irq all enabled", irq, 4'b1001);
      wr_en = 1'b1; wr_data = 8'hFF; cyc();
      wr_en = 1'b0; wr_data = 8'h00;
      chk("R10 reserved stay zero", rd_data, 0);
      chk("R11 irq after clear", irq, 0);
      irq_mask = 4'b0;
   endtask

   initial begin
      cyc(3);
      t_reset();
      rst_n = 1'b1; cyc();
      t_reset();
      t_compare();
      t_prescaled();
      t_force();
      t_capture();
      t_top();
      t_ovf();
      t_layout();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #20000;
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule